// File: doc/BRIEF.md
# Software-Refilled Translation Lookaside Buffer

This block is a set-associative translation cache. It holds page-table entries as pairs of 32-bit words, word 0 and word 1. Software fills it; the block never walks the page table. The instruction side and the data side are separate arrays of the same shape. A fetch searches only the instruction array, and a load or store searches only the data array. A lookup carries five things:

- the effective address
- the compare word that the entry's word 0 must hold
- the access key
- the no-execute flag
- the hash value

The block answers one cycle later with a hit, a protection fault or a miss.

On a hit or a fault, the block returns the translated address, the permissions and the updated word 1 of the chosen entry. It also writes the referenced bit, and the changed bit where the access earns it, back into storage. On a miss, it loads the registers a refill handler reads: the missed address, the compare word tagged as valid, two hash-group addresses and an error word carrying the key. The handler then writes the entry through the refill port, giving the side, the way and an address. The address supplies both the set index and the stored page number.

Top module: `soft_tlb`

## Requirements
- R1: An entry matches only if all four of these hold:
  - its stored page number equals address bits [31:12];
  - word 0 bit 31 (valid) is 1;
  - word 0 bit 6 (hash select) is 0;
  - word 0 ANDed with 0x7FFFFFBF equals the compare word.
- R2: Ways are examined from way 0 upward. The first matching way whose permissions allow the access is chosen, and no later way is read or changed.
- R3: A match is ignored when an earlier match has already been kept and this match's word 1 differs from the kept word 1 in any bit of mask 0xFFFFF07B. Those bits are the page number [31:12], the attributes [6:3] and the protection bits [1:0].
- R4: Permissions are returned as rspProt = {execute, write, read}, computed from the protection bits pp = word1[1:0]:
  - key 0: pp 3 gives read only; every other pp gives read and write.
  - key 1: pp 0 gives nothing; pp 2 gives read and write; pp 1 and pp 3 give read only.
  - Execute equals read AND NOT no-execute.
  - A fetch needs execute, a store needs write and a load needs read.
  - A matching entry that denies the access yields a fault.
- R5: A hit or a fault sets bit 8 (referenced) of the chosen entry's word 1, both in storage and in rspEntry.
- R6: If word1 bit 7 (changed) is clear, a granted store sets it. Any other access leaves it clear and clears the write bit of rspProt.
- R7: On a miss, the compare register of the searched side is loaded with the compare word OR 0x80000000, and the miss-address register of that side takes the address. The other side's registers keep their values. rspPaddr, rspProt and rspEntry read zero.
- R8: On a miss, the error word is loaded with key << 19. The hash addresses are loaded as follows:
  - hashAddr1 = base + ((hash AND mask) << 6);
  - hashAddr2 = base + ((NOT hash AND mask) << 6).
- R9: The instruction and data arrays are separate, and each is indexed by address bits [16:12]. A refill writes word 0, word 1 and the page number into the given side, way and set.
- R10: A request accepted on one edge gives rspValid on the next edge, with exactly one of rspHit, rspFault and rspMiss set. On a hit or fault, rspPaddr = {word1[31:12], address[11:0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Refill write strobe |
| wrFetchSide | input | 1 | Refill target: 1 instruction, 0 data |
| wrWay | input | WAYW | Refill way |
| wrAddr | input | 32 | Refill address (page number and set index) |
| wrWord0 | input | 32 | Refill word 0 |
| wrWord1 | input | 32 | Refill word 1 |
| reqValid | input | 1 | Lookup request |
| reqFetch | input | 1 | Request is an instruction fetch |
| reqStore | input | 1 | Request is a store (ignored for fetches) |
| reqAddr | input | 32 | Effective address |
| reqCmp | input | 32 | Compare word |
| reqKey | input | 1 | Access key |
| reqNoExec | input | 1 | No-execute flag of the segment |
| reqHash | input | 32 | Primary hash value |
| hashBase | input | 32 | Hash table base address |
| hashMask | input | 32 | Hash table mask |
| rspValid | output | 1 | Response present |
| rspHit | output | 1 | Access granted |
| rspFault | output | 1 | Match found, access denied |
| rspMiss | output | 1 | No usable match |
| rspPaddr | output | 32 | Physical address |
| rspProt | output | 3 | {execute, write, read} |
| rspEntry | output | 32 | Updated word 1 of the chosen entry |
| iMissAddr | output | 32 | Instruction miss address |
| iCmp | output | 32 | Instruction compare register |
| dMissAddr | output | 32 | Data miss address |
| dCmp | output | 32 | Data compare register |
| hashAddr1 | output | 32 | Primary hash-group address |
| hashAddr2 | output | 32 | Secondary hash-group address |
| missErr | output | 32 | Error word with the key at bit 19 |

## Verification
Every result is due on the clock edge that follows the edge accepting the request. This holds for:

- the outcome flags, address, permissions and entry word;
- the miss registers;
- the referenced and changed bits written back to storage.

The bench drives each request just after a falling edge and lets one rising edge pass. It compares every output with its model at the next falling edge, so no sample lands on an edge where the outputs are changing. State written back to storage is observed on a later lookup through rspEntry and rspProt.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int WAY_IDX_W = 4;
  localparam logic [31:0] CMP_FIELD_MASK = 32'h7FFF_FFBF;
  localparam logic [31:0] CONSIST_MASK   = 32'hFFFF_F07B;
  localparam int REF_BIT = 8;
  localparam int CHG_BIT = 7;

  typedef struct packed {
    logic hit;
    logic fault;
    logic miss;
    logic updEn;
    logic [WAY_IDX_W-1:0] updWay;
    logic [31:0] newW1;
    logic [2:0] prot;
  } tlbStrobes_t;

  function automatic logic [2:0] permOf(input logic key, input logic noExec,
                                        input logic [1:0] pp);
    logic rd, wr;
    if (key) begin
      rd = (pp != 2'd0);
      wr = (pp == 2'd2);
    end else begin
      rd = 1'b1;
      wr = (pp != 2'd3);
    end
    return {rd & ~noExec, wr, rd};
  endfunction
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl import tlb_pkg::*; #(
  parameter int WAYS = 2
) (
  input  logic        reqValid,
  input  logic        reqFetch,
  input  logic        reqStore,
  input  logic        reqKey,
  input  logic        reqNoExec,
  input  logic [31:0] reqCmp,
  input  logic [19:0] reqPage,
  input  logic [31:0] rdW0 [WAYS],
  input  logic [31:0] rdW1 [WAYS],
  input  logic [19:0] rdEpn [WAYS],
  output tlbStrobes_t strobes
);
  logic isStore;
  assign isStore = reqStore & ~reqFetch;

  always_comb begin
    logic found, granted, candidate, clash;
    logic [31:0] keptW1, nextW1;
    logic [2:0] perm;
    logic [WAY_IDX_W-1:0] best;
    found   = 1'b0;
    granted = 1'b0;
    keptW1  = '0;
    perm    = '0;
    best    = '0;
    for (int w = 0; w < WAYS; w++) begin
      candidate = ~granted && (rdEpn[w] == reqPage) && rdW0[w][31] &&
                  ~rdW0[w][6] && ((rdW0[w] & CMP_FIELD_MASK) == reqCmp);
      clash = found && (((keptW1 ^ rdW1[w]) & CONSIST_MASK) != '0);
      if (candidate && !clash) begin
        found  = 1'b1;
        best   = WAY_IDX_W'(w);
        keptW1 = rdW1[w];
        perm   = permOf(reqKey, reqNoExec, rdW1[w][1:0]);
        granted = reqFetch ? perm[2] : (isStore ? perm[1] : perm[0]);
      end
    end
    nextW1 = keptW1;
    nextW1[REF_BIT] = 1'b1;
    if (!keptW1[CHG_BIT]) begin
      if (isStore && granted) nextW1[CHG_BIT] = 1'b1;
      else perm[1] = 1'b0;
    end
    strobes.hit    = reqValid & granted;
    strobes.fault  = reqValid & found & ~granted;
    strobes.miss   = reqValid & ~found;
    strobes.updEn  = reqValid & found;
    strobes.updWay = best;
    strobes.newW1  = found ? nextW1 : '0;
    strobes.prot   = found ? perm : '0;
  end
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath import tlb_pkg::*; #(
  parameter int WAYS = 2,
  parameter int SETS = 32,
  localparam int WAYW = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int IDXW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            wrFetchSide,
  input  logic [WAYW-1:0] wrWay,
  input  logic [31:0]     wrAddr,
  input  logic [31:0]     wrWord0,
  input  logic [31:0]     wrWord1,
  input  logic            reqValid,
  input  logic            reqFetch,
  input  logic            reqStore,
  input  logic [31:0]     reqAddr,
  input  logic [31:0]     reqCmp,
  input  logic            reqKey,
  input  logic [31:0]     reqHash,
  input  logic [31:0]     hashBase,
  input  logic [31:0]     hashMask,
  input  tlbStrobes_t     strobes,
  output logic [31:0]     rdW0 [WAYS],
  output logic [31:0]     rdW1 [WAYS],
  output logic [19:0]     rdEpn [WAYS],
  output logic            rspValid,
  output logic            rspHit,
  output logic            rspFault,
  output logic            rspMiss,
  output logic [31:0]     rspPaddr,
  output logic [2:0]      rspProt,
  output logic [31:0]     rspEntry,
  output logic [31:0]     iMissAddr,
  output logic [31:0]     iCmp,
  output logic [31:0]     dMissAddr,
  output logic [31:0]     dCmp,
  output logic [31:0]     hashAddr1,
  output logic [31:0]     hashAddr2,
  output logic [31:0]     missErr
);
  logic [IDXW-1:0] reqIdx, wrIdx;
  logic [WAYW-1:0] updWay;
  assign reqIdx = reqAddr[12 +: IDXW];
  assign wrIdx  = wrAddr[12 +: IDXW];
  assign updWay = strobes.updWay[WAYW-1:0];

  logic [31:0] sideW0 [2][WAYS];
  logic [31:0] sideW1 [2][WAYS];
  logic [19:0] sideEpn [2][WAYS];

  for (genvar s = 0; s < 2; s++) begin : gSide
    logic [31:0] w0Mem [SETS][WAYS];
    logic [31:0] w1Mem [SETS][WAYS];
    logic [19:0] epnMem [SETS][WAYS];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < SETS; i++)
          for (int j = 0; j < WAYS; j++) begin
            w0Mem[i][j]  <= '0;
            w1Mem[i][j]  <= '0;
            epnMem[i][j] <= '0;
          end
      end else begin
        if (strobes.updEn && (reqFetch == 1'(s)))
          w1Mem[reqIdx][updWay] <= strobes.newW1;
        if (wrEn && (wrFetchSide == 1'(s))) begin
          w0Mem[wrIdx][wrWay]  <= wrWord0;
          w1Mem[wrIdx][wrWay]  <= wrWord1;
          epnMem[wrIdx][wrWay] <= wrAddr[31:12];
        end
      end
    end

    for (genvar w = 0; w < WAYS; w++) begin : gWay
      assign sideW0[s][w]  = w0Mem[reqIdx][w];
      assign sideW1[s][w]  = w1Mem[reqIdx][w];
      assign sideEpn[s][w] = epnMem[reqIdx][w];
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rdW0[w]  = reqFetch ? sideW0[1][w]  : sideW0[0][w];
      rdW1[w]  = reqFetch ? sideW1[1][w]  : sideW1[0][w];
      rdEpn[w] = reqFetch ? sideEpn[1][w] : sideEpn[0][w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspFault  <= 1'b0;
      rspMiss   <= 1'b0;
      rspPaddr  <= '0;
      rspProt   <= '0;
      rspEntry  <= '0;
      iMissAddr <= '0;
      iCmp      <= '0;
      dMissAddr <= '0;
      dCmp      <= '0;
      hashAddr1 <= '0;
      hashAddr2 <= '0;
      missErr   <= '0;
    end else begin
      rspValid <= reqValid;
      rspHit   <= strobes.hit;
      rspFault <= strobes.fault;
      rspMiss  <= strobes.miss;
      if (reqValid) begin
        rspProt  <= strobes.prot;
        rspEntry <= strobes.newW1;
        rspPaddr <= strobes.miss ? '0 : {strobes.newW1[31:12], reqAddr[11:0]};
      end
      if (strobes.miss) begin
        if (reqFetch) begin
          iCmp      <= reqCmp | 32'h8000_0000;
          iMissAddr <= reqAddr;
        end else begin
          dCmp      <= reqCmp | 32'h8000_0000;
          dMissAddr <= reqAddr;
        end
        hashAddr1 <= hashBase + ((reqHash & hashMask) << 6);
        hashAddr2 <= hashBase + ((~reqHash & hashMask) << 6);
        missErr   <= 32'(reqKey) << 19;
      end
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($countones({rspHit, rspFault, rspMiss}) == 1)); // R10
  AST_MISS_NO_PROT: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspMiss) |-> (rspProt == 3'b000 && rspEntry == '0)); // R7
  AST_FAULT_DENIES: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqStore && !reqFetch) |=> (rspFault |-> !rspProt[1])); // R4
  AST_MISS_CMP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqFetch) |=> (rspMiss |-> dCmp[31])); // R7
  AST_REF_RETURNED: assert property (@(posedge clk) disable iff (!rstN)
    (rspHit || rspFault) |-> rspEntry[8]); // R5
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb import tlb_pkg::*; #(
  parameter int WAYS = 2,
  parameter int SETS = 32,
  localparam int WAYW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            wrFetchSide,
  input  logic [WAYW-1:0] wrWay,
  input  logic [31:0]     wrAddr,
  input  logic [31:0]     wrWord0,
  input  logic [31:0]     wrWord1,
  input  logic            reqValid,
  input  logic            reqFetch,
  input  logic            reqStore,
  input  logic [31:0]     reqAddr,
  input  logic [31:0]     reqCmp,
  input  logic            reqKey,
  input  logic            reqNoExec,
  input  logic [31:0]     reqHash,
  input  logic [31:0]     hashBase,
  input  logic [31:0]     hashMask,
  output logic            rspValid,
  output logic            rspHit,
  output logic            rspFault,
  output logic            rspMiss,
  output logic [31:0]     rspPaddr,
  output logic [2:0]      rspProt,
  output logic [31:0]     rspEntry,
  output logic [31:0]     iMissAddr,
  output logic [31:0]     iCmp,
  output logic [31:0]     dMissAddr,
  output logic [31:0]     dCmp,
  output logic [31:0]     hashAddr1,
  output logic [31:0]     hashAddr2,
  output logic [31:0]     missErr
);
  tlbStrobes_t strobes;
  logic [31:0] rdW0 [WAYS];
  logic [31:0] rdW1 [WAYS];
  logic [19:0] rdEpn [WAYS];

  tlb_ctrl #(.WAYS(WAYS)) uCtrl (
    .reqValid(reqValid), .reqFetch(reqFetch), .reqStore(reqStore),
    .reqKey(reqKey), .reqNoExec(reqNoExec), .reqCmp(reqCmp),
    .reqPage(reqAddr[31:12]), .rdW0(rdW0), .rdW1(rdW1), .rdEpn(rdEpn),
    .strobes(strobes)
  );

  tlb_datapath #(.WAYS(WAYS), .SETS(SETS)) uData (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrFetchSide(wrFetchSide),
    .wrWay(wrWay), .wrAddr(wrAddr), .wrWord0(wrWord0), .wrWord1(wrWord1),
    .reqValid(reqValid), .reqFetch(reqFetch), .reqStore(reqStore),
    .reqAddr(reqAddr), .reqCmp(reqCmp), .reqKey(reqKey), .reqHash(reqHash),
    .hashBase(hashBase), .hashMask(hashMask), .strobes(strobes),
    .rdW0(rdW0), .rdW1(rdW1), .rdEpn(rdEpn),
    .rspValid(rspValid), .rspHit(rspHit), .rspFault(rspFault),
    .rspMiss(rspMiss), .rspPaddr(rspPaddr), .rspProt(rspProt),
    .rspEntry(rspEntry), .iMissAddr(iMissAddr), .iCmp(iCmp),
    .dMissAddr(dMissAddr), .dCmp(dCmp), .hashAddr1(hashAddr1),
    .hashAddr2(hashAddr2), .missErr(missErr)
  );
endmodule

// File: tb/tb_soft_tlb.sv
module tb_soft_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS = 2;
  localparam int SETS = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrFetchSide = 1'b0;
  logic [0:0] wrWay = '0;
  logic [31:0] wrAddr = '0, wrWord0 = '0, wrWord1 = '0;
  logic reqValid = 1'b0, reqFetch = 1'b0, reqStore = 1'b0, reqKey = 1'b0, reqNoExec = 1'b0;
  logic [31:0] reqAddr = '0, reqCmp = '0, reqHash = '0;
  logic [31:0] hashBase = 32'h00F0_0000, hashMask = 32'h0000_03FF;
  logic rspValid, rspHit, rspFault, rspMiss;
  logic [31:0] rspPaddr, rspEntry, iMissAddr, iCmp, dMissAddr, dCmp, hashAddr1, hashAddr2, missErr;
  logic [2:0] rspProt;

  always #(CLK_PERIOD/2) clk = ~clk;

  soft_tlb #(.WAYS(WAYS), .SETS(SETS)) dut (.*);

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // reference state
  logic [31:0] mW0 [2][SETS][WAYS];
  logic [31:0] mW1 [2][SETS][WAYS];
  logic [19:0] mEpn [2][SETS][WAYS];
  logic eValid, eHit, eFault, eMiss;
  logic [31:0] ePaddr, eEntry, eIMiss, eICmp, eDMiss, eDCmp, eH1, eH2, eErr;
  logic [2:0] eProt;
  string ctx = "reset";

  task automatic chk(string field, string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s [%s] %s: actual %h expected %h", tag, ctx, field, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("rspValid", "R10", 32'(rspValid), 32'(eValid));
    chk("rspHit",   "R10", 32'(rspHit),   32'(eHit));
    chk("rspFault", "R10", 32'(rspFault), 32'(eFault));
    chk("rspMiss",  "R10", 32'(rspMiss),  32'(eMiss));
    chk("rspPaddr", "R10", rspPaddr, ePaddr);
    chk("rspProt",  "R4",  32'(rspProt), 32'(eProt));
    chk("rspEntry", "R5",  rspEntry, eEntry);
    chk("iMissAddr","R7",  iMissAddr, eIMiss);
    chk("iCmp",     "R7",  iCmp, eICmp);
    chk("dMissAddr","R7",  dMissAddr, eDMiss);
    chk("dCmp",     "R7",  dCmp, eDCmp);
    chk("hashAddr1","R8",  hashAddr1, eH1);
    chk("hashAddr2","R8",  hashAddr2, eH2);
    chk("missErr",  "R8",  missErr, eErr);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(string c);
    ctx = c;
    wrEn = 0; reqValid = 0;
    eValid = 0; eHit = 0; eFault = 0; eMiss = 0;
    tick();
  endtask

  task automatic refill(string c, bit side, int way, logic [31:0] a, logic [31:0] w0, logic [31:0] w1);
    int idx;
    ctx = c;
    idx = int'(a[16:12]);
    wrEn = 1; wrFetchSide = side; wrWay = 1'(way); wrAddr = a; wrWord0 = w0; wrWord1 = w1;
    reqValid = 0;
    mW0[side][idx][way] = w0; mW1[side][idx][way] = w1; mEpn[side][idx][way] = a[31:12];
    eValid = 0; eHit = 0; eFault = 0; eMiss = 0;
    tick();
    wrEn = 0;
  endtask

  function automatic logic [2:0] refPerm(bit key, bit nx, logic [1:0] pp);
    bit r, w;
    case ({key, pp})
      3'b000, 3'b001, 3'b010: begin r = 1; w = 1; end
      3'b011:                 begin r = 1; w = 0; end
      3'b100:                 begin r = 0; w = 0; end
      3'b110:                 begin r = 1; w = 1; end
      default:                begin r = 1; w = 0; end
    endcase
    return {r && !nx, w, r};
  endfunction

  task automatic access(string c, bit fetch, bit store, logic [31:0] a, logic [31:0] cmp,
                        bit key, bit nx, logic [31:0] hsh);
    int idx, pick;
    bit side, wantSt, ok;
    logic [31:0] kept;
    logic [2:0] p;
    ctx = c;
    side = fetch; wantSt = store && !fetch; idx = int'(a[16:12]);
    pick = -1; ok = 0; kept = 0; p = 0;
    wrEn = 0; reqValid = 1; reqFetch = fetch; reqStore = store; reqAddr = a;
    reqCmp = cmp; reqKey = key; reqNoExec = nx; reqHash = hsh;
    for (int w = 0; w < WAYS && !ok; w++) begin
      if (mEpn[side][idx][w] != a[31:12]) continue;
      if (mW0[side][idx][w][31] !== 1'b1 || mW0[side][idx][w][6] !== 1'b0) continue;
      if ({1'b0, mW0[side][idx][w][30:7], 1'b0, mW0[side][idx][w][5:0]} != cmp) continue;
      if (pick >= 0 && ((kept ^ mW1[side][idx][w]) & 32'hFFFF_F07B) != 0) continue;
      pick = w; kept = mW1[side][idx][w];
      p = refPerm(key, nx, kept[1:0]);
      ok = fetch ? p[2] : (wantSt ? p[1] : p[0]);
    end
    eValid = 1;
    if (pick >= 0) begin
      kept[8] = 1;
      if (!kept[7]) begin
        if (wantSt && ok) kept[7] = 1;
        else p[1] = 0;
      end
      mW1[side][idx][pick] = kept;
      eHit = ok; eFault = !ok; eMiss = 0;
      eProt = p; eEntry = kept; ePaddr = {kept[31:12], a[11:0]};
    end else begin
      eHit = 0; eFault = 0; eMiss = 1;
      eProt = 0; eEntry = 0; ePaddr = 0;
      if (fetch) begin eICmp = cmp | 32'h8000_0000; eIMiss = a; end
      else begin eDCmp = cmp | 32'h8000_0000; eDMiss = a; end
      eH1 = hashBase + ((hsh & hashMask) * 64);
      eH2 = hashBase + ((~hsh & hashMask) * 64);
      eErr = key ? 32'h0008_0000 : 32'h0;
    end
    tick();
    reqValid = 0;
  endtask

  localparam logic [31:0] W0A  = 32'h8000_0000 | (32'h00ABCD << 7) | 32'h11;
  localparam logic [31:0] CMPA = W0A & 32'h7FFF_FFFF;
  localparam logic [31:0] W0B  = 32'h8000_0000 | (32'h000777 << 7) | 32'h05;
  localparam logic [31:0] CMPB = W0B & 32'h7FFF_FFFF;

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < SETS; i++)
        for (int w = 0; w < WAYS; w++) begin
          mW0[s][i][w] = 0; mW1[s][i][w] = 0; mEpn[s][i][w] = 0;
        end
    eValid = 0; eHit = 0; eFault = 0; eMiss = 0; ePaddr = 0; eEntry = 0; eProt = 0;
    eIMiss = 0; eICmp = 0; eDMiss = 0; eDCmp = 0; eH1 = 0; eH2 = 0; eErr = 0;
    repeat (3) @(negedge clk);
    compareAll();               // reset state, R10/R7/R8 registers at zero
    rstN = 1;
    idle("after reset");

    // R9 R4 R6: load on clean page removes write, sets referenced
    refill("R9 data refill", 0, 0, 32'h1234_5000, W0A, 32'hABCD_E002);
    access("R6 first load", 0, 0, 32'h1234_5ABC, CMPA, 0, 0, 32'h0);
    access("R6 granted store sets changed", 0, 1, 32'h1234_5ABC, CMPA, 0, 0, 32'h0);
    access("R6 load after changed", 0, 0, 32'h1234_5010, CMPA, 0, 0, 32'h0);
    idle("idle");
    // R7 R8: data miss on compare mismatch, key 1
    access("R7 R8 data miss", 0, 0, 32'h1234_5000, CMPB, 1, 0, 32'h0000_1234);
    // R9: fetch does not see data entry
    access("R9 fetch side separate", 1, 0, 32'h1234_5000, CMPA, 0, 0, 32'h0000_0055);
    refill("R9 instr refill", 1, 1, 32'h1234_5000, W0A, 32'h0004_4001);
    access("R4 fetch hit", 1, 0, 32'h1234_5444, CMPA, 0, 0, 32'h0);
    access("R4 fetch no-exec fault", 1, 0, 32'h1234_5444, CMPA, 0, 1, 32'h0);
    // R4: key 1 with pp 0 denies load
    refill("R4 refill", 0, 1, 32'h0000_7000, W0B, 32'h0070_0000);
    access("R4 key1 pp0 fault", 0, 0, 32'h0000_7008, CMPB, 1, 0, 32'h0);
    access("R4 key0 pp0 store", 0, 1, 32'h0000_7008, CMPB, 0, 0, 32'h0);
    // R1: hash-select, invalid, page mismatch
    refill("R1 hash-select set", 0, 0, 32'h0000_9000, W0B | 32'h40, 32'h0090_0002);
    access("R1 hash-select ignored", 0, 0, 32'h0000_9000, CMPB, 0, 0, 32'h0000_0FF0);
    refill("R1 invalid entry", 0, 1, 32'h0000_9000, W0B & 32'h7FFF_FFFF, 32'h0091_0002);
    access("R1 invalid ignored", 0, 0, 32'h0000_9000, CMPB, 0, 0, 32'h0);
    access("R1 page mismatch", 0, 0, 32'h0010_5000, CMPA, 0, 0, 32'h0000_0001);
    // R2: first granted way chosen, later way untouched
    refill("R2 way0", 0, 0, 32'h0000_3000, W0A, 32'h0030_0002);
    refill("R2 way1", 0, 1, 32'h0000_3000, W0A, 32'h0030_0002);
    access("R2 store hits way0", 0, 1, 32'h0000_3004, CMPA, 0, 0, 32'h0);
    refill("R2 kill way0", 0, 0, 32'h0000_3000, 32'h0, 32'h0);
    access("R2 way1 untouched", 0, 0, 32'h0000_3004, CMPA, 0, 0, 32'h0);
    // R3: later inconsistent match ignored
    refill("R3 way0 read-only", 0, 0, 32'h0000_4000, W0A, 32'h0040_0003);
    refill("R3 way1 differs", 0, 1, 32'h0000_4000, W0A, 32'h0040_0002);
    access("R3 inconsistent ignored", 0, 1, 32'h0000_4000, CMPA, 0, 0, 32'h0);
    // R9: top set index
    refill("R9 set 31", 0, 1, 32'hFFFF_F000, W0B, 32'hCAFE_0082);
    access("R9 set 31 hit", 0, 0, 32'hFFFF_FFFC, CMPB, 0, 0, 32'h0);
    access("R8 instr miss key1", 1, 0, 32'hFFFF_F000, CMPB, 1, 0, 32'hFFFF_FFFF);
    idle("final idle");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule